// File: doc/BRIEF.md
# Variable Width Branch Unit

This block works out the next instruction pointer for the jump instructions of a byte-coded processor. On each cycle that a request is valid, it takes the address of the opcode byte, the opcode, the zero flag, a two-bit code for the active address width, and an operand of up to 64 bits. The operand bytes have already been fetched and assembled little-endian. One clock later it returns the next instruction pointer and a flag that shows whether the branch was taken.

Three kinds of jump are handled. An absolute jump loads a target that is zero-extended from the active width. A relative jump adds a sign-extended offset to the address just past the offset field. Conditional jumps test the zero flag. A conditional jump that is not taken still steps over its operand bytes. The memory size is a power of two, so every result is reduced to the low address bits, and an address wraps past the top of memory or below zero.

Top module: `brj_branch_unit`

## Requirements
- R1: Opcode 4 always jumps: next_ip_o is the operand field, zero-extended and taken from the active width, and taken_o is 1.
- R2: Opcode 5 jumps to the absolute target when zf_i is 1. Opcode 6 jumps to it when zf_i is 0.
- R3: Opcode 7 always jumps to (ip_i + 1 + width bytes + offset). The offset is the operand field at the active width, read as two's complement and sign-extended to 64 bits.
- R4: Opcode 8 makes the relative jump of R3 when zf_i is 1. Opcode 9 makes it when zf_i is 0.
- R5: size_i selects the width of the operand field: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Operand bits above that field have no effect on the result.
- R6: When a conditional jump (opcode 5, 6, 8 or 9) is not taken, next_ip_o is ip_i + 1 + width bytes and taken_o is 0.
- R7: Every next_ip_o is reduced modulo MEM_BYTES by keeping its low log2(MEM_BYTES) bits. This applies to overflow past the top of memory and to relative targets that fall below zero.
- R8: valid_o is 1 exactly one clock after a cycle with valid_i = 1. taken_o is 1 only together with valid_o.
- R9: Any opcode other than 4 to 9 still gives a result: valid_o is 1, taken_o is 0, and next_ip_o equals ip_i.
- R10: While reset is asserted, valid_o, taken_o and next_ip_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid this cycle |
| ip_i | input | IPW | Address of the opcode byte |
| opcode_i | input | 8 | Instruction opcode |
| zf_i | input | 1 | Zero flag |
| size_i | input | 2 | Active address width code |
| operand_i | input | 64 | Assembled operand, little-endian |
| valid_o | output | 1 | Result valid |
| next_ip_o | output | IPW | Next instruction pointer |
| taken_o | output | 1 | Pointer loaded from the branch target |

## Verification
Each result is due on the rising edge that follows the edge at which its request was sampled. That is one register stage, so the outputs change one cycle after the request. The driver places each request on a falling edge and pushes the expected pointer and taken flag into a queue. The monitor compares valid outputs on the next falling edge, half a period after the register updates. A valid output with nothing queued, and an item left in the queue at the end, both count as failures.

// File: rtl/brj_pkg.sv
package brj_pkg;
   localparam int OPND_W = 64;
   localparam int OPC_W  = 8;

   typedef enum logic [1:0] {
      SZ_B1 = 2'd0,
      SZ_B2 = 2'd1,
      SZ_B4 = 2'd2,
      SZ_B8 = 2'd3
   } opnd_size_e;

   localparam logic [OPC_W-1:0] OPC_JA    = 8'd4;
   localparam logic [OPC_W-1:0] OPC_JA_Z  = 8'd5;
   localparam logic [OPC_W-1:0] OPC_JA_NZ = 8'd6;
   localparam logic [OPC_W-1:0] OPC_JR    = 8'd7;
   localparam logic [OPC_W-1:0] OPC_JR_Z  = 8'd8;
   localparam logic [OPC_W-1:0] OPC_JR_NZ = 8'd9;
endpackage

// File: rtl/brj_opnd_shape.sv
module brj_opnd_shape
   import brj_pkg::*;
(
   input  opnd_size_e        size_i,
   input  logic [OPND_W-1:0] raw_i,
   output logic [OPND_W-1:0] zext_o,
   output logic [OPND_W-1:0] sext_o,
   output logic [3:0]        nbytes_o
);
   localparam int N_SIZES = 4;

   logic [OPND_W-1:0] zc [N_SIZES];
   logic [OPND_W-1:0] sc [N_SIZES];

   // One candidate per width, picked by the size code
   for (genvar g = 0; g < N_SIZES; g++) begin : g_sz
      localparam int FW = 8 << g;
      if (FW < OPND_W) begin : g_part
         assign zc[g] = {{(OPND_W-FW){1'b0}}, raw_i[FW-1:0]};
         assign sc[g] = {{(OPND_W-FW){raw_i[FW-1]}}, raw_i[FW-1:0]};
      end else begin : g_full
         assign zc[g] = raw_i;
         assign sc[g] = raw_i;
      end
   end

   always_comb begin
      zext_o   = zc[size_i];
      sext_o   = sc[size_i];
      nbytes_o = 4'd1 << size_i;
   end
endmodule

// File: rtl/brj_cond.sv
module brj_cond
   import brj_pkg::*;
(
   input  logic [OPC_W-1:0] opcode_i,
   input  logic             zf_i,
   output logic             is_branch_o,
   output logic             is_rel_o,
   output logic             take_o
);
   always_comb begin
      is_branch_o = 1'b1;
      is_rel_o    = 1'b0;
      take_o      = 1'b0;
      case (opcode_i)
         OPC_JA:    take_o = 1'b1;
         OPC_JA_Z:  take_o = zf_i;
         OPC_JA_NZ: take_o = ~zf_i;
         OPC_JR:    begin is_rel_o = 1'b1; take_o = 1'b1;  end
         OPC_JR_Z:  begin is_rel_o = 1'b1; take_o = zf_i;  end
         OPC_JR_NZ: begin is_rel_o = 1'b1; take_o = ~zf_i; end
         default:   is_branch_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/brj_addr.sv
module brj_addr
   import brj_pkg::*;
#(
   parameter int IPW = 16
) (
   input  logic [IPW-1:0]    ip_i,
   input  logic [3:0]        nbytes_i,
   input  logic [OPND_W-1:0] zext_i,
   input  logic [OPND_W-1:0] sext_i,
   input  logic              is_branch_i,
   input  logic              is_rel_i,
   input  logic              take_i,
   output logic [IPW-1:0]    next_o
);
   logic [OPND_W-1:0] seq_full;
   logic [OPND_W-1:0] rel_full;

   always_comb begin
      seq_full = OPND_W'(ip_i) + OPND_W'(nbytes_i) + OPND_W'(1);
      rel_full = seq_full + sext_i;
      if (!is_branch_i)
         next_o = ip_i;
      else if (!take_i)
         next_o = seq_full[IPW-1:0];
      else if (is_rel_i)
         next_o = rel_full[IPW-1:0];
      else
         next_o = zext_i[IPW-1:0];
   end
endmodule

// File: rtl/brj_branch_unit.sv
module brj_branch_unit
   import brj_pkg::*;
#(
   parameter  int MEM_BYTES = 65536,
   localparam int IPW       = $clog2(MEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [IPW-1:0]    ip_i,
   input  logic [OPC_W-1:0]  opcode_i,
   input  logic              zf_i,
   input  logic [1:0]        size_i,
   input  logic [OPND_W-1:0] operand_i,
   output logic              valid_o,
   output logic [IPW-1:0]    next_ip_o,
   output logic              taken_o
);
   if (MEM_BYTES < 2 || (MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_mem
      $error("MEM_BYTES must be a power of two of at least 2");
   end

   logic [OPND_W-1:0] zext, sext;
   logic [3:0]        nbytes;
   logic              is_branch, is_rel, take;
   logic [IPW-1:0]    next_c;

   brj_opnd_shape u_shape (
      .size_i   (opnd_size_e'(size_i)),
      .raw_i    (operand_i),
      .zext_o   (zext),
      .sext_o   (sext),
      .nbytes_o (nbytes)
   );

   brj_cond u_cond (
      .opcode_i    (opcode_i),
      .zf_i        (zf_i),
      .is_branch_o (is_branch),
      .is_rel_o    (is_rel),
      .take_o      (take)
   );

   brj_addr #(.IPW(IPW)) u_addr (
      .ip_i        (ip_i),
      .nbytes_i    (nbytes),
      .zext_i      (zext),
      .sext_i      (sext),
      .is_branch_i (is_branch),
      .is_rel_i    (is_rel),
      .take_i      (take),
      .next_o      (next_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o   <= 1'b0;
         next_ip_o <= '0;
         taken_o   <= 1'b0;
      end else begin
         valid_o   <= valid_i;
         taken_o   <= valid_i & take;
         if (valid_i) next_ip_o <= next_c;
      end
   end

   p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o);
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> (!valid_o && !taken_o));
   p_uncond_abs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && opcode_i == OPC_JA && size_i == 2'd3)
      |=> (taken_o && next_ip_o == $past(operand_i[IPW-1:0])));
   p_skip_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && opcode_i == OPC_JA_Z && !zf_i && size_i == 2'd0)
      |=> (!taken_o && next_ip_o == IPW'($past(ip_i) + IPW'(2))));
   p_other_opc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (opcode_i < OPC_JA || opcode_i > OPC_JR_NZ))
      |=> (!taken_o && next_ip_o == $past(ip_i)));
endmodule

// File: tb/sim_brj_branch_unit.sv
module sim_brj_branch_unit;
   localparam int CLK_PERIOD = 10;
   localparam int IPW = 16;

   typedef struct {
      logic [IPW-1:0] ip;
      bit             tk;
      string          tag;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           valid_i = 1'b0;
   logic [IPW-1:0] ip_i = '0;
   logic [7:0]     opcode_i = '0;
   logic           zf_i = 1'b0;
   logic [1:0]     size_i = '0;
   logic [63:0]    operand_i = '0;
   logic           valid_o;
   logic [IPW-1:0] next_ip_o;
   logic           taken_o;

   int   total = 0;
   int   bad = 0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   brj_branch_unit u0 (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .ip_i(ip_i),
      .opcode_i(opcode_i), .zf_i(zf_i), .size_i(size_i), .operand_i(operand_i),
      .valid_o(valid_o), .next_ip_o(next_ip_o), .taken_o(taken_o)
   );

   // Expected result, taken from the requirement text
   function automatic exp_t model(logic [IPW-1:0] ip, logic [7:0] opc, logic z,
                                  logic [1:0] sz, logic [63:0] opnd, string tag);
      exp_t e;
      logic [63:0] nb, mask, fld, sfld, seq;
      bit cond;
      nb   = 64'd1 << sz;
      mask = (sz == 2'd3) ? '1 : ((64'd1 << (nb * 8)) - 1);
      fld  = opnd & mask;
      sfld = fld;
      if (sz != 2'd3 && fld[nb*8-1]) sfld = fld | ~mask;
      seq  = 64'(ip) + 1 + nb;
      e.tag = tag;
      case (opc)
         8'd4, 8'd7: cond = 1'b1;
         8'd5, 8'd8: cond = z;
         8'd6, 8'd9: cond = !z;
         default:    cond = 1'b0;
      endcase
      e.tk = cond;
      if (opc < 8'd4 || opc > 8'd9) e.ip = ip;
      else if (!cond)               e.ip = seq[IPW-1:0];
      else if (opc >= 8'd7)         e.ip = 16'(seq + sfld);
      else                          e.ip = fld[IPW-1:0];
      return e;
   endfunction

   task automatic issue(logic [IPW-1:0] ip, logic [7:0] opc, logic z,
                        logic [1:0] sz, logic [63:0] opnd, string tag);
      @(negedge clk);
      valid_i = 1'b1; ip_i = ip; opcode_i = opc; zf_i = z; size_i = sz; operand_i = opnd;
      sb.push_back(model(ip, opc, z, sz, opnd, tag));
   endtask

   task automatic go_idle();
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   // Monitor: results are due one edge after the request
   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL R8: unexpected valid_o, next_ip=%h", next_ip_o);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (next_ip_o !== e.ip || taken_o !== e.tk) begin
               bad++;
               $display("FAIL %s: got ip=%h taken=%b, expected ip=%h taken=%b",
                        e.tag, next_ip_o, taken_o, e.ip, e.tk);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 3);
      @(negedge clk);
      total++;
      if (valid_o !== 1'b0 || taken_o !== 1'b0 || next_ip_o !== '0) begin
         bad++;
         $display("FAIL R10: got v=%b t=%b ip=%h, expected 0 0 0", valid_o, taken_o, next_ip_o);
      end
      rst_n = 1'b1;

      issue(16'h0010, 8'd4, 1'b0, 2'd1, 64'hFFFF_FFFF_FFFF_1234, "R1 abs 2B");
      issue(16'h0020, 8'd4, 1'b1, 2'd0, 64'h0000_0000_0000_01AB, "R5 abs 1B high ignored");
      issue(16'h0030, 8'd4, 1'b0, 2'd2, 64'h0000_0000_0012_3456, "R7 abs 4B masked");
      issue(16'h0040, 8'd5, 1'b1, 2'd1, 64'h0000_0000_0000_0500, "R2 jz taken");
      issue(16'h0040, 8'd5, 1'b0, 2'd1, 64'h0000_0000_0000_0500, "R6 jz not taken");
      issue(16'h0050, 8'd6, 1'b0, 2'd0, 64'h0000_0000_0000_0077, "R2 jnz taken");
      issue(16'h0050, 8'd6, 1'b1, 2'd2, 64'h0000_0000_0000_0077, "R6 jnz not taken 4B");
      issue(16'h0100, 8'd7, 1'b0, 2'd0, 64'h0000_0000_0000_00F0, "R3 rel back 1B");
      issue(16'h0200, 8'd7, 1'b1, 2'd1, 64'hABCD_0000_0000_0010, "R5 rel fwd 2B");
      issue(16'h0300, 8'd8, 1'b1, 2'd0, 64'h0000_0000_0000_0008, "R4 jrz taken");
      issue(16'h0300, 8'd8, 1'b0, 2'd0, 64'h0000_0000_0000_0008, "R6 jrz not taken");
      issue(16'h0400, 8'd9, 1'b0, 2'd2, 64'h0000_0000_FFFF_FFFC, "R4 jrnz taken 4B");
      issue(16'h0400, 8'd9, 1'b1, 2'd3, 64'h0000_0000_FFFF_FFFC, "R6 jrnz not taken 8B");
      issue(16'hFFFE, 8'd7, 1'b0, 2'd3, 64'h0000_0000_0000_0005, "R7 rel wrap top");
      issue(16'h0002, 8'd7, 1'b0, 2'd1, 64'h0000_0000_0000_FFF0, "R7 rel wrap below zero");
      issue(16'hFFFC, 8'd5, 1'b0, 2'd3, 64'h0, "R7 skip wrap");
      issue(16'h1234, 8'd17, 1'b1, 2'd1, 64'h0000_0000_0000_0099, "R9 other opcode");
      issue(16'h4321, 8'd3, 1'b0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R9 opcode below range");
      go_idle();
      @(negedge clk);
      total++;
      if (valid_o !== 1'b0 || taken_o !== 1'b0) begin
         bad++;
         $display("FAIL R8: got v=%b t=%b when idle, expected 0 0", valid_o, taken_o);
      end
      total++;
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL R8: got %0d results missing, expected 0", sb.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule